// File: doc/BRIEF.md
# CPU Interrupt Entry Sequencer

This block carries out the entry half of interrupt handling for an 8-bit processor that has a 16-bit program counter. While the core is idle, the block watches four request sources:

- a reset request,
- a non-maskable request taken on its falling edge,
- a level-sensitive maskable request,
- a software break request.

When one of them is accepted, the block takes a snapshot of the current program counter, status byte and stack pointer. For every source except reset, it then writes three bytes of return context to a stack that is fixed in memory page one. After that it fetches a 16-bit handler address from a fixed vector pair chosen by the request type. It sets the interrupt-disable flag and reports the new program counter with a one-cycle valid pulse.

The memory bus is byte wide, with separate write and read strobes. Read data must be valid during the same cycle as the read strobe, and it is sampled at the clock edge that ends that cycle. The updated stack pointer and status byte are presented on their own outputs. The surrounding core loads them when the valid pulse appears.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset of the block, both memory strobes are low, the new-PC-valid output is low and the busy output is low.
- R2: A non-reset entry performs exactly three write cycles in this order: PC bits 15:8, then PC bits 7:0, then the status byte. Each write goes to address {0x01, SP}, where SP is the stack pointer value at the start of that write.
- R3: Each write decrements the stack pointer by one, modulo 256, so a starting SP of 0x01 writes to 0x0101, 0x0100 and 0x01FF and leaves SP at 0xFE.
- R4: After any pushes, the handler address is read in two consecutive single-cycle reads, the lower address first. The address pairs are 0xFFFA/0xFFFB for NMI, 0xFFFC/0xFFFD for reset, and 0xFFFE/0xFFFF for both IRQ and break. The write and read strobes are never active together.
- R5: New-PC-valid is high for exactly one cycle, in the cycle right after the read of the high vector byte. The new PC equals {byte read from the higher address, byte read from the lower address}.
- R6: The status byte written to the stack carries the interrupt-disable flag (bit 2) as it was at entry. The status output has bit 2 set when new-PC-valid is high.
- R7: The stacked status byte has bit 4 set to 1 for a software break and cleared to 0 for IRQ and NMI. Every other stacked status bit is copied from the status input.
- R8: A low IRQ input (active low) starts no entry while status input bit 2 is 1: no strobe and no new-PC-valid appear.
- R9: NMI (active low) starts an entry only on a high-to-low transition. Holding it low produces exactly one entry.
- R10: When requests coincide, reset wins over NMI, NMI wins over IRQ, and IRQ wins over break. Requests are accepted only while the block is idle, and a pending NMI edge is kept until it is served.
- R11: A reset entry performs no writes, leaves the stack pointer unchanged, sets status bit 2, and discards any pending NMI edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| reset_req | input | 1 | CPU reset request, active high |
| nmi_n | input | 1 | Non-maskable request, active low, edge sensitive |
| irq_n | input | 1 | Maskable request, active low, level sensitive |
| brk_req | input | 1 | Software break request, active high |
| pc_in | input | 16 | Current program counter |
| status_in | input | 8 | Current status byte |
| sp_in | input | 8 | Current stack pointer |
| mem_rdata | input | 8 | Read data, valid in the read-strobe cycle |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| sp_out | output | 8 | Updated stack pointer |
| status_out | output | 8 | Updated status byte |
| pc_new | output | 16 | Handler address |
| pc_valid | output | 1 | One-cycle pulse: new PC ready |
| busy | output | 1 | A sequence is in progress |

## Verification
Each request type is run on its own. Because each type has a distinct vector pair and a distinct stacked status pattern, a wrong vector selection or a wrong break bit shows up at once.

- **Stack pointer wrap:** a starting stack pointer of 0x01 separates a correct modulo-256 wrap from a borrow into the page byte.
- **Masking:** IRQ held low with the disable flag set checks masking.
- **NMI edge:** NMI held low for many cycles separates edge detection from level detection.
- **Priority:** coincident reset, NMI and IRQ, and then coincident NMI and IRQ, check the priority order and that reset drops the pending NMI edge.

// File: rtl/ise_pkg.sv
package ise_pkg;
  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_RST  = 3'd1,
    K_NMI  = 3'd2,
    K_IRQ  = 3'd3,
    K_BRK  = 3'd4
  } kind_t;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_PCH  = 3'd1,
    S_PCL  = 3'd2,
    S_PST  = 3'd3,
    S_VLO  = 3'd4,
    S_VHI  = 3'd5,
    S_DONE = 3'd6
  } state_t;
endpackage

// File: rtl/ise_nmi_edge.sv
module ise_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic clr,
  output logic req
);
  logic prev_q, prev_n;
  logic pend_q, pend_n;
  logic fall;

  assign fall = prev_q & ~nmi_n;
  assign req  = pend_q | fall;

  always_comb begin
    prev_n = nmi_n;
    pend_n = clr ? 1'b0 : (pend_q | fall);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= prev_n;
      pend_q <= pend_n;
    end
  end

  AST_EDGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !clr) |=> pend_q); // R10
  AST_LEVEL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_q && !pend_q) |-> !req); // R9
endmodule

// File: rtl/ise_arbiter.sv
module ise_arbiter
  import ise_pkg::*;
#(
  parameter int IFLAG_BIT = 2
) (
  input  logic       reset_req,
  input  logic       nmi_req,
  input  logic       irq_n,
  input  logic       brk_req,
  input  logic [7:0] status_in,
  output kind_t      kind
);
  logic irq_ok;
  assign irq_ok = ~irq_n & ~status_in[IFLAG_BIT];

  always_comb begin
    if (reset_req)    kind = K_RST;
    else if (nmi_req) kind = K_NMI;
    else if (irq_ok)  kind = K_IRQ;
    else if (brk_req) kind = K_BRK;
    else              kind = K_NONE;
  end
endmodule

// File: rtl/ise_bus_drv.sv
module ise_bus_drv
  import ise_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 8,
  parameter int          BRK_BIT    = 4,
  parameter logic [7:0]  STACK_PAGE = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  state_t            state,
  input  kind_t             kind,
  input  logic [7:0]        sp,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] stat,
  input  logic [ADDR_W-1:0] vec,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re
);
  localparam int PAGE_W = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] ONE = 1;

  logic [DATA_W-1:0] stat_push;

  always_comb begin
    stat_push          = stat;
    stat_push[BRK_BIT] = (kind == K_BRK);
  end

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    case (state)
      S_PCH: begin
        mem_we    = 1'b1;
        mem_addr  = {PAGE_W'(STACK_PAGE), sp};
        mem_wdata = pc[ADDR_W-1 -: DATA_W];
      end
      S_PCL: begin
        mem_we    = 1'b1;
        mem_addr  = {PAGE_W'(STACK_PAGE), sp};
        mem_wdata = pc[DATA_W-1:0];
      end
      S_PST: begin
        mem_we    = 1'b1;
        mem_addr  = {PAGE_W'(STACK_PAGE), sp};
        mem_wdata = stat_push;
      end
      S_VLO: begin
        mem_re   = 1'b1;
        mem_addr = vec;
      end
      S_VHI: begin
        mem_re   = 1'b1;
        mem_addr = vec + ONE;
      end
      default: ;
    endcase
  end

  AST_WR_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[ADDR_W-1:8] == PAGE_W'(STACK_PAGE))); // R2
  AST_RD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_VLO) |=> (mem_re && mem_addr == $past(mem_addr) + ONE)); // R4
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import ise_pkg::*;
#(
  parameter int             ADDR_W    = 16,
  parameter int             DATA_W    = 8,
  parameter int             IFLAG_BIT = 2,
  parameter int             BRK_BIT   = 4,
  parameter logic [7:0]     STACK_PAGE = 8'h01,
  parameter logic [15:0]    VEC_NMI   = 16'hFFFA,
  parameter logic [15:0]    VEC_RST   = 16'hFFFC,
  parameter logic [15:0]    VEC_IRQ   = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_req,
  input  logic              nmi_n,
  input  logic              irq_n,
  input  logic              brk_req,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] status_in,
  input  logic [7:0]        sp_in,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [7:0]        sp_out,
  output logic [DATA_W-1:0] status_out,
  output logic [ADDR_W-1:0] pc_new,
  output logic              pc_valid,
  output logic              busy
);
  localparam int LO_W = DATA_W;

  state_t            st_q, st_n;
  kind_t             kind_q, kind_n, kind_arb;
  logic [ADDR_W-1:0] pc_q, pc_n;
  logic [ADDR_W-1:0] vec_q, vec_n;
  logic [7:0]        sp_q, sp_n;
  logic [DATA_W-1:0] stat_q, stat_n;
  logic              nmi_req, nmi_clr, idle;

  assign idle    = (st_q == S_IDLE);
  assign nmi_clr = idle & ((kind_arb == K_NMI) | (kind_arb == K_RST));

  ise_nmi_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .nmi_n (nmi_n),
    .clr   (nmi_clr),
    .req   (nmi_req)
  );

  ise_arbiter #(.IFLAG_BIT(IFLAG_BIT)) u_arb (
    .reset_req (reset_req),
    .nmi_req   (nmi_req),
    .irq_n     (irq_n),
    .brk_req   (brk_req),
    .status_in (status_in),
    .kind      (kind_arb)
  );

  function automatic logic [ADDR_W-1:0] vec_of(kind_t k);
    case (k)
      K_RST:   vec_of = ADDR_W'(VEC_RST);
      K_NMI:   vec_of = ADDR_W'(VEC_NMI);
      default: vec_of = ADDR_W'(VEC_IRQ);
    endcase
  endfunction

  always_comb begin
    st_n   = st_q;
    kind_n = kind_q;
    pc_n   = pc_q;
    vec_n  = vec_q;
    sp_n   = sp_q;
    stat_n = stat_q;
    case (st_q)
      S_IDLE: begin
        if (kind_arb != K_NONE) begin
          kind_n = kind_arb;
          pc_n   = pc_in;
          sp_n   = sp_in;
          stat_n = status_in;
          vec_n  = vec_of(kind_arb);
          if (kind_arb == K_RST) begin
            stat_n[IFLAG_BIT] = 1'b1;
            st_n = S_VLO;
          end else begin
            st_n = S_PCH;
          end
        end
      end
      S_PCH: begin
        sp_n = sp_q - 8'd1;
        st_n = S_PCL;
      end
      S_PCL: begin
        sp_n = sp_q - 8'd1;
        st_n = S_PST;
      end
      S_PST: begin
        sp_n = sp_q - 8'd1;
        stat_n[IFLAG_BIT] = 1'b1;
        st_n = S_VLO;
      end
      S_VLO: begin
        pc_n[LO_W-1:0] = mem_rdata;
        st_n = S_VHI;
      end
      S_VHI: begin
        pc_n[ADDR_W-1:LO_W] = mem_rdata;
        st_n = S_DONE;
      end
      S_DONE: st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      kind_q <= K_NONE;
      pc_q   <= '0;
      vec_q  <= '0;
      sp_q   <= '0;
      stat_q <= '0;
    end else begin
      st_q   <= st_n;
      kind_q <= kind_n;
      pc_q   <= pc_n;
      vec_q  <= vec_n;
      sp_q   <= sp_n;
      stat_q <= stat_n;
    end
  end

  ise_bus_drv #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BRK_BIT(BRK_BIT), .STACK_PAGE(STACK_PAGE)
  ) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (st_q),
    .kind      (kind_q),
    .sp        (sp_q),
    .pc        (pc_q),
    .stat      (stat_q),
    .vec       (vec_q),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re)
  );

  assign pc_valid   = (st_q == S_DONE);
  assign pc_new     = pc_q;
  assign sp_out     = sp_q;
  assign status_out = stat_q;
  assign busy       = ~idle;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R4
  AST_PV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_valid |=> !pc_valid); // R5
  AST_PV_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    pc_valid |-> $past(mem_re)); // R5
  AST_PV_IFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    pc_valid |-> status_out[IFLAG_BIT]); // R6
  AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp_out == $past(sp_out) - 8'd1)); // R3
  AST_RST_NOWR: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && reset_req) |=> !mem_we); // R11
endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reset_req, nmi_n, irq_n, brk_req;
  logic [15:0] pc_in;
  logic [7:0]  status_in, sp_in, mem_rdata;
  logic [15:0] mem_addr, pc_new;
  logic [7:0]  mem_wdata, sp_out, status_out;
  logic        mem_we, mem_re, pc_valid, busy;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .nmi_n(nmi_n),
    .irq_n(irq_n), .brk_req(brk_req), .pc_in(pc_in), .status_in(status_in),
    .sp_in(sp_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .sp_out(sp_out), .status_out(status_out), .pc_new(pc_new),
    .pc_valid(pc_valid), .busy(busy)
  );

  always_comb begin
    case (mem_addr)
      16'hFFFA: mem_rdata = 8'h11;
      16'hFFFB: mem_rdata = 8'h22;
      16'hFFFC: mem_rdata = 8'h33;
      16'hFFFD: mem_rdata = 8'h44;
      16'hFFFE: mem_rdata = 8'h55;
      16'hFFFF: mem_rdata = 8'h66;
      default:  mem_rdata = 8'h00;
    endcase
  end

  logic [15:0] wa [8];
  logic [7:0]  wd [8];
  logic [15:0] ra [8];
  int nw, nr, nv, cyc, last_rd, v_cyc, both;
  logic [15:0] v_pc;
  logic [7:0]  v_sp, v_st;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mem_we && mem_re) both <= both + 1;
    if (mem_we) begin
      if (nw < 8) begin wa[nw] <= mem_addr; wd[nw] <= mem_wdata; end
      nw <= nw + 1;
    end
    if (mem_re) begin
      if (nr < 8) ra[nr] <= mem_addr;
      nr <= nr + 1;
      last_rd <= cyc;
    end
    if (pc_valid) begin
      nv <= nv + 1; v_cyc <= cyc; v_pc <= pc_new; v_sp <= sp_out; v_st <= status_out;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clr_log();
    @(negedge clk);
    #1;
    nw = 0; nr = 0; nv = 0; both = 0; last_rd = -100; v_cyc = -200;
  endtask

  task automatic pulse_req(input bit r, input bit nmi, input bit irq, input bit brk);
    @(negedge clk);
    reset_req = r; brk_req = brk;
    if (nmi) nmi_n = 1'b0;
    if (irq) irq_n = 1'b0;
    @(posedge clk); #1;
    reset_req = 1'b0; brk_req = 1'b0; irq_n = 1'b1;
    repeat (12) @(negedge clk);
    nmi_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_entry(input string req, input logic [15:0] pc,
                             input logic [7:0] sp, input logic [7:0] st_exp,
                             input logic [15:0] vec, input logic [15:0] hnd);
    chk(nw == 3, req, "write count", nw, 3);
    chk(wa[0] == {8'h01, sp} && wd[0] == pc[15:8], req, "push1 PCH", {wa[0], wd[0]}, {8'h01, sp, pc[15:8]});
    chk(wa[1] == {8'h01, sp - 8'd1} && wd[1] == pc[7:0], req, "push2 PCL", {wa[1], wd[1]}, {8'h01, sp - 8'd1, pc[7:0]});
    chk(wa[2] == {8'h01, sp - 8'd2} && wd[2] == st_exp, req, "push3 status", {wa[2], wd[2]}, {8'h01, sp - 8'd2, st_exp});
    chk(nr == 2 && ra[0] == vec && ra[1] == vec + 16'd1, req, "vector reads", {ra[0], ra[1]}, {vec, vec + 16'd1});
    chk(nv == 1 && v_cyc == last_rd + 1, req, "valid pulse timing", v_cyc - last_rd, 1);
    chk(v_pc == hnd, req, "new pc", v_pc, hnd);
    chk(v_sp == sp - 8'd3, req, "sp after entry", v_sp, sp - 8'd3);
    chk(v_st[2] == 1'b1, req, "I flag set", v_st, st_exp | 8'h04);
    chk(both == 0, req, "strobe overlap", both, 0);
  endtask

  task automatic t_reset_state();
    chk(!mem_we && !mem_re && !pc_valid && !busy, "R1", "idle outputs",
        {mem_we, mem_re, pc_valid, busy}, 0);
  endtask

  task automatic t_irq();
    clr_log(); pc_in = 16'h1234; sp_in = 8'hFF; status_in = 8'h20;
    pulse_req(0, 0, 1, 0);
    check_entry("R2 R4 R5 R6 R7", 16'h1234, 8'hFF, 8'h20, 16'hFFFE, 16'h6655);
  endtask

  task automatic t_brk();
    clr_log(); pc_in = 16'hABCD; sp_in = 8'h80; status_in = 8'hC1;
    pulse_req(0, 0, 0, 1);
    check_entry("R7 brk", 16'hABCD, 8'h80, 8'hD1, 16'hFFFE, 16'h6655);
  endtask

  task automatic t_nmi_hold();
    clr_log(); pc_in = 16'h0F0E; sp_in = 8'h40; status_in = 8'h14;
    pulse_req(0, 1, 0, 0);
    check_entry("R9 nmi", 16'h0F0E, 8'h40, 8'h04, 16'hFFFA, 16'h2211);
  endtask

  task automatic t_wrap();
    clr_log(); pc_in = 16'h5AA5; sp_in = 8'h01; status_in = 8'h00;
    pulse_req(0, 0, 1, 0);
    chk(wa[2] == 16'h01FF, "R3", "wrapped third push", wa[2], 16'h01FF);
    chk(v_sp == 8'hFE, "R3", "sp after wrap", v_sp, 8'hFE);
  endtask

  task automatic t_masked();
    clr_log(); status_in = 8'h04;
    @(negedge clk); irq_n = 1'b0;
    repeat (15) @(negedge clk);
    chk(nw == 0 && nr == 0 && nv == 0 && !busy, "R8", "masked irq activity", nw + nr + nv, 0);
    irq_n = 1'b1; status_in = 8'h00;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset_entry();
    clr_log(); pc_in = 16'h7777; sp_in = 8'h55; status_in = 8'h00;
    pulse_req(1, 1, 1, 0);
    chk(nw == 0, "R11 R10", "writes on reset", nw, 0);
    chk(nr == 2 && ra[0] == 16'hFFFC && ra[1] == 16'hFFFD, "R10", "reset vector reads", ra[0], 16'hFFFC);
    chk(nv == 1 && v_pc == 16'h4433, "R11", "reset new pc", v_pc, 16'h4433);
    chk(v_sp == 8'h55 && v_st[2], "R11", "reset sp/I", {v_sp, v_st}, {8'h55, 8'h04});
  endtask

  task automatic t_nmi_over_irq();
    clr_log(); pc_in = 16'h2000; sp_in = 8'hF0; status_in = 8'h00;
    pulse_req(0, 1, 1, 0);
    chk(nr == 2 && ra[0] == 16'hFFFA, "R10", "nmi beats irq", ra[0], 16'hFFFA);
    chk(nv == 1 && v_pc == 16'h2211, "R10", "single nmi entry", v_pc, 16'h2211);
  endtask

  initial begin
    rst_n = 1'b0; reset_req = 0; nmi_n = 1; irq_n = 1; brk_req = 0;
    pc_in = 0; status_in = 0; sp_in = 0; cyc = 0;
    nw = 0; nr = 0; nv = 0; both = 0; last_rd = -100; v_cyc = -200;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset_state();
    t_irq();
    t_brk();
    t_nmi_hold();
    t_wrap();
    t_masked();
    t_reset_entry();
    t_nmi_over_irq();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule